// File: doc/BRIEF.md
# Pattern-Stepped Six-Tap Polyphase Line Scaler

This block resamples one line of pixel components at a time, horizontally or vertically. Each output is a weighted sum over a six-entry window of input components. There are up to eight coefficient sets, called phases, and the phase index moves by one with every output. A pattern bitmask sets the scaling ratio. Its bit for the current phase decides whether the window takes in one new input after the output is taken, or keeps the same inputs for the next output.

A line begins with a component flagged as start-of-line. That component fills the whole window, and the phase restarts at zero. Coefficients are loaded through a write-only port, and each one is narrowed to the range its tap position allows. Products are summed at full precision and scaled down by 2^14, so 0x4000 is unity gain. Results are clipped to the pixel range. The output uses a valid/ready handshake and stalls whenever the window is waiting for input.

Top module: `pattern_polyphase_scaler`

## Requirements
- R1: During and right after reset, `out_valid` is 0 and `in_ready` is 1, and no line is open.
- R2: A write stores `cfg_wdata` at address {phase[2:0], tap[2:0]}. Tap 0 is the oldest window entry (in[-3]), tap 3 is the current pixel (in[0]) and tap 5 is the newest (in[+2]). Tap codes 6 and 7 are ignored. Taps 0 and 5 keep the low 11 bits, sign-extended; taps 1 and 4 keep the low 13 bits, sign-extended; taps 2 and 3 keep all 16 bits. Bits 3:0 of every stored coefficient read as zero.
- R3: A start-of-line input is accepted in any state (`in_ready` is high whenever `in_sol` is high). It loads all six window entries with its value and sets the phase to 0.
- R4: While `out_valid` is high, `out_data` equals floor(sum over taps of window[t]*coef[phase][t] / 2^14), clamped to the pixel range.
- R5: A negative weighted result gives 0, and a result above 2^DATA_W-1 gives 2^DATA_W-1.
- R6: Each output handshake moves the phase from p to p+1, or to 0 when p equals `cfg_len`. Without a handshake or restart, the phase holds.
- R7: After an output handshake, if `cfg_patt[phase]` was 1, the window drops its valid state and `in_ready` rises. The next non-start input then shifts in at tap 5. If the bit was 0, the window is kept and the next output follows with no input consumed.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays stable, provided no coefficient write and no start-of-line input arrives.
- R9: A non-start input arriving while no line is open is accepted and discarded.
- R10: When a start-of-line input and an output handshake happen in the same cycle, the restart wins and the next output uses the fresh window at phase 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_addr | input | PW+3 | {phase, tap} of the coefficient to write |
| cfg_wdata | input | 16 | Raw coefficient value |
| cfg_len | input | PW | Number of used phases minus one |
| cfg_patt | input | PHASES | Advance bit per phase |
| in_valid | input | 1 | Input component valid |
| in_sol | input | 1 | Input component starts a line |
| in_data | input | DATA_W | Input component |
| in_ready | output | 1 | Scaler accepts the input this cycle |
| out_valid | output | 1 | Output component available |
| out_ready | input | 1 | Consumer takes the output |
| out_data | output | DATA_W | Scaled, clipped component |

## Verification
Two functions can fall in the same cycle: the output handshake, which advances the phase and may release the window, and a start-of-line restart, which reloads the window and zeroes the phase. The bench provokes the collision by raising `out_ready` and a start-of-line input on the same clock, in the middle of a multi-phase line. It then compares the next output against a model window freshly filled at phase 0. A stall held across several cycles, partway through a line, is checked separately for a stable output.

// File: rtl/pps_pkg.sv
package pps_pkg;
   localparam int TAPS        = 6;
   localparam int COEF_W      = 16;
   localparam int COEF_DROP   = 4;
   localparam int UNITY_SHIFT = 14;

   // significant bits kept for each tap position (outer taps narrowest)
   function automatic int tap_bits(input int t);
      if (t == 0 || t == TAPS - 1) return 11;
      if (t == 1 || t == TAPS - 2) return 13;
      return COEF_W;
   endfunction

   // narrow, sign-extend and clear the ignored low bits
   function automatic logic [COEF_W-1:0] fit_coef(input logic [COEF_W-1:0] raw,
                                                  input int bits);
      logic signed [COEF_W-1:0] s;
      s = $signed(raw << (COEF_W - bits)) >>> (COEF_W - bits);
      return COEF_W'(s) & ~COEF_W'((1 << COEF_DROP) - 1);
   endfunction
endpackage

// File: rtl/pps_coef_bank.sv
module pps_coef_bank
   import pps_pkg::*;
#(
   parameter int PHASES = 8,
   parameter int PW     = $clog2(PHASES)
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wr_en,
   input  logic [PW-1:0]                  wr_phase,
   input  logic [2:0]                     wr_tap,
   input  logic [COEF_W-1:0]              wr_data,
   input  logic [PW-1:0]                  rd_phase,
   output logic [TAPS-1:0][COEF_W-1:0]    rd_coef
);
   for (genvar t = 0; t < TAPS; t++) begin : g_tap
      localparam int BITS = tap_bits(t);
      logic [COEF_W-1:0] mem [PHASES];

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            for (int p = 0; p < PHASES; p++) mem[p] <= '0;
         end else if (wr_en && wr_tap == 3'(t)) begin
            mem[wr_phase] <= fit_coef(wr_data, BITS);
         end
      end

      assign rd_coef[t] = mem[rd_phase];

      if (BITS < COEF_W) begin : g_range_chk
         // R2: a narrowed tap never holds a value outside its range
         p_tap_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
            ($signed(rd_coef[t]) >= -(32'sd1 << (BITS - 1))) &&
            ($signed(rd_coef[t]) <  (32'sd1 << (BITS - 1))));
      end
   end
endmodule

// File: rtl/pps_phase_seq.sv
module pps_phase_seq #(
   parameter int PHASES = 8,
   parameter int PW     = $clog2(PHASES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PW-1:0]     len,
   input  logic [PHASES-1:0] patt,
   input  logic              restart,
   input  logic              step,
   output logic [PW-1:0]     phase,
   output logic              adv
);
   always_ff @(posedge clk) begin
      if (!rst_n)       phase <= '0;
      else if (restart) phase <= '0;
      else if (step)    phase <= (phase == len) ? '0 : PW'(phase + 1'b1);
   end

   assign adv = patt[phase];

   // R10: a restart always lands on phase 0, even with a handshake beside it
   p_restart_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> phase == '0);
   // R6: no handshake, no restart, no movement
   p_phase_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !restart && !step |=> $stable(phase));
   // R6: the last used phase wraps to zero
   p_phase_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      step && !restart && phase == len |=> phase == '0);
endmodule

// File: rtl/pps_window.sv
module pps_window
   import pps_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         in_valid,
   input  logic                         in_sol,
   input  logic [DATA_W-1:0]            in_data,
   output logic                         in_ready,
   input  logic                         consume,
   input  logic                         adv,
   output logic [TAPS-1:0][DATA_W-1:0]  win,
   output logic                         win_valid,
   output logic                         restart
);
   logic line_open;
   logic take;

   assign in_ready = !win_valid || in_sol;
   assign take     = in_valid && in_ready;
   assign restart  = take && in_sol;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         win       <= '0;
         win_valid <= 1'b0;
         line_open <= 1'b0;
      end else if (restart) begin
         for (int i = 0; i < TAPS; i++) win[i] <= in_data;
         win_valid <= 1'b1;
         line_open <= 1'b1;
      end else if (take && line_open) begin
         for (int i = 0; i < TAPS - 1; i++) win[i] <= win[i+1];
         win[TAPS-1] <= in_data;
         win_valid   <= 1'b1;
      end else if (consume && adv) begin
         win_valid <= 1'b0;
      end
   end

   // R3: start of line replicates the pixel across the window
   p_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> win_valid && win[0] == $past(in_data) && win[TAPS-1] == $past(in_data));
   // R7: a zero pattern bit keeps the window intact
   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      consume && !adv && !restart |=> win_valid && $stable(win));
   // R7: a one pattern bit releases the window for the next input
   p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
      consume && adv && !restart |=> !win_valid);
   // R9: data before any start of line is dropped
   p_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      take && !in_sol && !line_open |=> !win_valid);
endmodule

// File: rtl/pps_mac.sv
module pps_mac
   import pps_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic [TAPS-1:0][DATA_W-1:0]  win,
   input  logic [TAPS-1:0][COEF_W-1:0]  coef,
   output logic [DATA_W-1:0]            pix
);
   localparam int ACC_W = DATA_W + COEF_W + 1 + $clog2(TAPS) + 1;
   localparam logic signed [ACC_W-1:0] PIX_MAX = ACC_W'({DATA_W{1'b1}});

   logic signed [ACC_W-1:0] prod [TAPS];
   logic signed [ACC_W-1:0] acc;
   logic signed [ACC_W-1:0] scaled;

   for (genvar t = 0; t < TAPS; t++) begin : g_mul
      assign prod[t] = ACC_W'($signed({1'b0, win[t]})) * ACC_W'($signed(coef[t]));
   end

   always_comb begin
      acc = '0;
      for (int t = 0; t < TAPS; t++) acc = acc + prod[t];
      scaled = acc >>> UNITY_SHIFT;
      if (scaled < 0)            pix = '0;
      else if (scaled > PIX_MAX) pix = {DATA_W{1'b1}};
      else                       pix = scaled[DATA_W-1:0];
   end
endmodule

// File: rtl/pattern_polyphase_scaler.sv
module pattern_polyphase_scaler
   import pps_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int PHASES = 8,
   parameter int PW     = $clog2(PHASES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [PW+2:0]     cfg_addr,
   input  logic [15:0]       cfg_wdata,
   input  logic [PW-1:0]     cfg_len,
   input  logic [PHASES-1:0] cfg_patt,
   input  logic              in_valid,
   input  logic              in_sol,
   input  logic [DATA_W-1:0] in_data,
   output logic              in_ready,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [DATA_W-1:0] out_data
);
   if (PHASES < 2 || (1 << PW) != PHASES) begin : g_bad_phases
      $error("PHASES must be a power of two of at least 2");
   end
   if (DATA_W < 2 || DATA_W > 16) begin : g_bad_width
      $error("DATA_W must lie between 2 and 16");
   end

   logic                        fire;
   logic                        adv;
   logic                        restart;
   logic [PW-1:0]               phase;
   logic [TAPS-1:0][DATA_W-1:0] win;
   logic [TAPS-1:0][COEF_W-1:0] coef;

   assign fire = out_valid && out_ready;

   pps_coef_bank #(.PHASES(PHASES), .PW(PW)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (cfg_we),
      .wr_phase (cfg_addr[PW+2:3]),
      .wr_tap   (cfg_addr[2:0]),
      .wr_data  (cfg_wdata),
      .rd_phase (phase),
      .rd_coef  (coef)
   );

   pps_phase_seq #(.PHASES(PHASES), .PW(PW)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .len     (cfg_len),
      .patt    (cfg_patt),
      .restart (restart),
      .step    (fire),
      .phase   (phase),
      .adv     (adv)
   );

   pps_window #(.DATA_W(DATA_W)) u_win (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_sol    (in_sol),
      .in_data   (in_data),
      .in_ready  (in_ready),
      .consume   (fire),
      .adv       (adv),
      .win       (win),
      .win_valid (out_valid),
      .restart   (restart)
   );

   pps_mac #(.DATA_W(DATA_W)) u_mac (
      .win  (win),
      .coef (coef),
      .pix  (out_data)
   );

   // R8: a stalled output neither vanishes nor changes
   p_stall_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready && !cfg_we && !(in_valid && in_sol)
      |=> out_valid && $stable(out_data));
endmodule

// File: tb/tb_pattern_polyphase_scaler.sv
module tb_pattern_polyphase_scaler;
   localparam int DW = 8;
   localparam int PH = 8;
   localparam int PMAX = (1 << DW) - 1;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          cfg_we;
   logic [5:0]    cfg_addr;
   logic [15:0]   cfg_wdata;
   logic [2:0]    cfg_len;
   logic [PH-1:0] cfg_patt;
   logic          in_valid, in_sol, in_ready, out_valid, out_ready;
   logic [DW-1:0] in_data, out_data;

   always #10 clk = ~clk;

   pattern_polyphase_scaler #(.DATA_W(DW), .PHASES(PH)) dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_len(cfg_len), .cfg_patt(cfg_patt),
      .in_valid(in_valid), .in_sol(in_sol), .in_data(in_data),
      .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
      .out_data(out_data)
   );

   int n_vec = 0;
   int n_bad = 0;
   bit done  = 0;

   int mc [PH][6];
   int mw [6];
   int mph;
   int mlen;
   logic [PH-1:0] mpatt;
   logic [31:0] seed = 32'h1234_5678;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int next_pix();
      seed = seed * 32'd1103515245 + 32'd12345;
      return int'(seed[23:16]);
   endfunction

   // R2 rule: keep the tap's significant bits, sign-extend, clear bits 3:0
   function automatic int fit(input int t, input int v);
      int sw, x;
      sw = (t == 0 || t == 5) ? 11 : (t == 1 || t == 4) ? 13 : 16;
      x  = v & ((1 << sw) - 1);
      if (x >= (1 << (sw - 1))) x -= (1 << sw);
      return x & ~15;
   endfunction

   // R4/R5 arithmetic
   function automatic int expect_out();
      longint s = 0;
      for (int t = 0; t < 6; t++) s += longint'(mw[t]) * longint'(mc[mph][t]);
      s = s >>> 14;
      if (s < 0) return 0;
      if (s > PMAX) return PMAX;
      return int'(s);
   endfunction

   task automatic write_coef(input int ph, input int t, input int v);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = {3'(ph), 3'(t)}; cfg_wdata = 16'(v);
      @(negedge clk);
      cfg_we = 1'b0;
      if (t < 6) mc[ph][t] = fit(t, v);
   endtask

   task automatic clear_coefs();
      for (int p = 0; p < PH; p++)
         for (int t = 0; t < 6; t++) write_coef(p, t, 0);
   endtask

   task automatic set_cfg(input int len, input logic [PH-1:0] patt);
      cfg_len = 3'(len); cfg_patt = patt; mlen = len; mpatt = patt;
   endtask

   task automatic send(input int pix, input bit sol);
      in_valid = 1'b1; in_sol = sol; in_data = DW'(pix);
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      in_valid = 1'b0; in_sol = 1'b0;
   endtask

   task automatic run_line(input int n_out, input int restart_at, input int stall_at,
                           input string lbl);
      int pix, e, bitv;
      string tag;
      pix = next_pix();
      for (int t = 0; t < 6; t++) mw[t] = pix;
      mph = 0;
      send(pix, 1'b1);
      for (int k = 0; k < n_out; k++) begin
         while (!out_valid) @(negedge clk);
         e = expect_out();
         if (k == 0) tag = "R3";
         else if (k == restart_at + 1) tag = "R10";
         else tag = lbl;
         chk(out_data == DW'(e), tag, int'(out_data), e);
         if (k == stall_at) begin
            repeat (4) begin
               @(negedge clk);
               chk(out_valid && out_data == DW'(e), "R8", int'(out_data), e);
            end
         end
         if (k == restart_at) begin
            // R10: restart and output handshake on the same edge
            pix = next_pix();
            in_valid = 1'b1; in_sol = 1'b1; in_data = DW'(pix); out_ready = 1'b1;
            @(negedge clk);
            in_valid = 1'b0; in_sol = 1'b0; out_ready = 1'b0;
            for (int t = 0; t < 6; t++) mw[t] = pix;
            mph = 0;
         end else begin
            out_ready = 1'b1;
            @(negedge clk);
            out_ready = 1'b0;
            bitv = int'(mpatt[mph]);
            mph = (mph == mlen) ? 0 : mph + 1;
            chk(int'(in_ready) == bitv, "R7", int'(in_ready), bitv);
            if (bitv != 0) begin
               pix = next_pix();
               for (int t = 0; t < 5; t++) mw[t] = mw[t+1];
               mw[5] = pix;
               send(pix, 1'b0);
            end
         end
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_vec++; n_bad++;
         $display("FAIL run-time limit: got %0d expected %0d", 0, 1);
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
      in_valid = 1'b0; in_sol = 1'b0; in_data = '0; out_ready = 1'b0;
      for (int p = 0; p < PH; p++) for (int t = 0; t < 6; t++) mc[p][t] = 0;
      set_cfg(0, 8'b1);
      repeat (3) @(negedge clk);
      chk(out_valid == 1'b0, "R1", int'(out_valid), 0);
      chk(in_ready == 1'b1, "R1", int'(in_ready), 1);
      rst_n = 1'b1;
      @(negedge clk);
      chk(out_valid == 1'b0, "R1", int'(out_valid), 0);
      chk(in_ready == 1'b1, "R1", int'(in_ready), 1);

      // R9: stray data before any start of line
      for (int i = 0; i < 4; i++) begin
         send(next_pix(), 1'b0);
         chk(out_valid == 1'b0, "R9", int'(out_valid), 0);
         chk(in_ready == 1'b1, "R9", int'(in_ready), 1);
      end

      // unity on the current tap, one input per output
      write_coef(0, 3, 16'h4000);
      run_line(300, -1, -1, "R4");

      // R2: narrowing of each tap, ignored low bits, ignored tap code 6
      write_coef(0, 3, 16'h400F);
      write_coef(0, 0, 16'h07F0);
      write_coef(0, 5, 16'h0C40);
      write_coef(0, 1, 16'h1200);
      write_coef(0, 4, 16'h0050);
      write_coef(0, 2, 16'hF00A);
      write_coef(0, 6, 16'h7FFF);
      run_line(60, -1, -1, "R2");

      // R6: three phases, 3 outputs per 2 inputs, with stall and restart
      clear_coefs();
      set_cfg(2, 8'b0000_0011);
      write_coef(0, 3, 16'h4000);
      write_coef(1, 2, 16'h2000);
      write_coef(1, 3, 16'h2000);
      write_coef(2, 1, 16'hFC00);
      write_coef(2, 2, 16'h2400);
      write_coef(2, 3, 16'h2000);
      run_line(200, 91, 20, "R6");

      // R4: all eight phases with varied coefficients
      set_cfg(7, 8'b0110_1101);
      for (int p = 0; p < PH; p++)
         for (int t = 0; t < 6; t++)
            write_coef(p, t, (t == 3) ? (16'h3000 + next_pix() * 32) : ((next_pix() - 128) * 64));
      run_line(300, 150, 77, "R4");

      // R5: gain above unity and strongly negative gain
      clear_coefs();
      set_cfg(1, 8'b0000_0001);
      write_coef(0, 3, 16'h7FF0);
      write_coef(1, 3, 16'h8000);
      write_coef(1, 4, 16'h0FF0);
      run_line(200, -1, -1, "R5");

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule